// File: doc/BRIEF.md
# Serial Link Transceiver Reset Sequencer

This block releases the resets of a serial link transceiver in a fixed order while the link comes up. An active-low power-on reset controls the serializer/deserializer reset. After that reset is released, the transmit digital reset stays asserted until the transmit PLL has reported lock without a break for a fixed number of clock cycles.

The receive side follows a small training state machine. The machine starts in a quiet detect state. It moves to an active detect state once the receive PLL locks. It reaches the polling state when the PHY reports that receiver detection has finished. While the machine is in polling, the receive digital reset is released only after the signal-detect input has stayed high for a window of several milliseconds. That window is a cycle count computed from a clock-frequency parameter, so a simulation can use a much shorter value.

All reset outputs come straight from flip-flops, so they cannot glitch. The power-on reset input is sampled on the clock edge and acts as the block's synchronous reset.

Top module: `srs_top`

## Requirements
- R1: While `por_n` is low, `serdes_rst` is 1. On the first clock edge at which `por_n` is sampled high, `serdes_rst` goes to 0.
- R2: `tx_dig_rst` goes to 0 on the edge at which `tx_pll_lock` has been sampled high with `serdes_rst` low on TX_LOCK_CYCLES (127) consecutive edges. It never goes to 0 earlier.
- R3: An edge at which `tx_pll_lock` is sampled low sets `tx_dig_rst` to 1 and restarts the 127-cycle count from zero.
- R4: `link_state` encodes quiet detect as 0, active detect as 1 and polling as 2. From quiet detect, the state moves to 1 on the edge at which `rx_pll_lock` is sampled high, and it stays 0 otherwise.
- R5: In active detect, an edge that samples `phy_status` = 1 together with `rx_status` = 3'd3 moves the state to 2.
- R6: In active detect, `phy_status` with any `rx_status` other than 3, or `rx_status` = 3 without `phy_status`, leaves the state at 1.
- R7: `rx_dig_rst` is 1 whenever the state is not polling. In polling, it goes to 0 on the edge that completes CLK_KHZ*WINDOW_MS consecutive high samples of `sig_det`. Counting starts with the first edge after the state becomes 2.
- R8: An edge that samples `sig_det` low while in polling sets `rx_dig_rst` to 1 and restarts the window from zero.
- R9: An edge that samples `por_n` low, at any time, sets `serdes_rst`, `tx_dig_rst` and `rx_dig_rst` to 1 and `link_state` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| tx_pll_lock | input | 1 | Transmit PLL lock |
| rx_pll_lock | input | 1 | Receive PLL lock |
| phy_status | input | 1 | PHY status pulse |
| rx_status | input | 3 | PHY receive status code; 3 means a receiver was detected |
| sig_det | input | 1 | Receive signal detect |
| serdes_rst | output | 1 | Serializer/deserializer reset, active high |
| tx_dig_rst | output | 1 | Transmit digital reset, active high |
| rx_dig_rst | output | 1 | Receive digital reset, active high |
| link_state | output | 2 | Training state: 0 quiet detect, 1 active detect, 2 polling |

## Verification
Every output is a single register stage from the inputs that drive it. A change in `por_n`, a PLL lock, or the PHY status and code therefore shows up one edge after it is sampled. A reset release shows up on exactly the edge that completes its count (the 127th lock sample, or the CLK_KHZ*WINDOW_MS-th signal-detect sample). The bench drives inputs and samples outputs 5 ns after each rising edge. It steps a counted number of edges to the cycle just before a release, checks that the reset is still asserted, then steps one more edge and checks the release. In the random phase, a bench model keeps consecutive-sample counters updated from the inputs present at each edge and compares them with the outputs after that edge.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    LS_QUIET  = 2'd0,
    LS_ACTIVE = 2'd1,
    LS_POLL   = 2'd2
  } link_st_e;

  localparam logic [2:0] RX_DETECTED = 3'd3;
endpackage

// File: rtl/srs_stable_cnt.sv
module srs_stable_cnt #(
  parameter int unsigned HOLD_CYCLES = 127
) (
  input  logic clk,
  input  logic clr,
  input  logic cond,
  output logic rst_q
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !cond) begin
      cnt   <= '0;
      rst_q <= 1'b1;
    end else if (cnt == LAST) begin
      rst_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      rst_q <= 1'b1;
    end
  end

  // R3 R8
  hold_on_drop_chk: assert property (@(posedge clk) disable iff (clr)
    !cond |=> rst_q);

  // R2 R7
  release_at_count_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(rst_q) |-> (cnt == LAST));
endmodule

// File: rtl/srs_train_fsm.sv
module srs_train_fsm
  import srs_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       rx_pll_lock,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  output link_st_e   state
);
  logic detect_done;
  assign detect_done = phy_status && (rx_status == RX_DETECTED);

  always_ff @(posedge clk) begin
    if (clr) begin
      state <= LS_QUIET;
    end else begin
      unique case (state)
        LS_QUIET:  if (rx_pll_lock) state <= LS_ACTIVE;
        LS_ACTIVE: if (detect_done) state <= LS_POLL;
        LS_POLL:   state <= LS_POLL;
        default:   state <= LS_QUIET;
      endcase
    end
  end

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (state == LS_QUIET && !rx_pll_lock) |=> (state == LS_QUIET));

  // R6
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (clr)
    (state == LS_ACTIVE && !(phy_status && rx_status == 3'd3)) |=> (state == LS_ACTIVE));

  // R4
  legal_state_chk: assert property (@(posedge clk) disable iff (clr)
    state != 2'd3);
endmodule

// File: rtl/srs_top.sv
module srs_top
  import srs_pkg::*;
#(
  parameter int unsigned CLK_KHZ        = 125000,
  parameter int unsigned WINDOW_MS      = 3,
  parameter int unsigned TX_LOCK_CYCLES = 127
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tx_pll_lock,
  input  logic       rx_pll_lock,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  input  logic       sig_det,
  output logic       serdes_rst,
  output logic       tx_dig_rst,
  output logic       rx_dig_rst,
  output logic [1:0] link_state
);
  localparam int unsigned WIN_CYCLES = CLK_KHZ * WINDOW_MS;

  logic     clr;
  link_st_e state;
  logic     tx_cond;
  logic     rx_clr;

  assign clr = !por_n;

  always_ff @(posedge clk) begin
    serdes_rst <= clr;
  end

  assign tx_cond = tx_pll_lock && !serdes_rst;

  srs_stable_cnt #(.HOLD_CYCLES(TX_LOCK_CYCLES)) u_tx_cnt (
    .clk   (clk),
    .clr   (clr),
    .cond  (tx_cond),
    .rst_q (tx_dig_rst)
  );

  srs_train_fsm u_fsm (
    .clk         (clk),
    .clr         (clr),
    .rx_pll_lock (rx_pll_lock),
    .phy_status  (phy_status),
    .rx_status   (rx_status),
    .state       (state)
  );

  assign rx_clr = clr || (state != LS_POLL);

  srs_stable_cnt #(.HOLD_CYCLES(WIN_CYCLES)) u_rx_cnt (
    .clk   (clk),
    .clr   (rx_clr),
    .cond  (sig_det),
    .rst_q (rx_dig_rst)
  );

  assign link_state = state;

  // R1
  serdes_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |=> !serdes_rst);

  // R7
  rx_only_in_poll_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rx_dig_rst |-> (link_state == 2'd2));

  // R2
  tx_after_serdes_chk: assert property (@(posedge clk) disable iff (!por_n)
    !tx_dig_rst |-> !serdes_rst);
endmodule

// File: tb/sim_srs_top.sv
module sim_srs_top;
  localparam int W = 60;
  localparam int TXN = 127;

  logic clk = 1'b0;
  logic por_n, tx_pll_lock, rx_pll_lock, phy_status, sig_det;
  logic [2:0] rx_status;
  logic serdes_rst, tx_dig_rst, rx_dig_rst;
  logic [1:0] link_state;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srs_top #(.CLK_KHZ(20), .WINDOW_MS(3), .TX_LOCK_CYCLES(TXN)) u0 (
    .clk(clk), .por_n(por_n), .tx_pll_lock(tx_pll_lock), .rx_pll_lock(rx_pll_lock),
    .phy_status(phy_status), .rx_status(rx_status), .sig_det(sig_det),
    .serdes_rst(serdes_rst), .tx_dig_rst(tx_dig_rst), .rx_dig_rst(rx_dig_rst),
    .link_state(link_state)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_rst(input int run, input int need);
    return (run < need) ? 1'b1 : 1'b0;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tx_run, rx_run;
    por_n = 0; tx_pll_lock = 0; rx_pll_lock = 0; phy_status = 0; rx_status = 0; sig_det = 0;
    tick(3);
    // R9 reset state
    chk("R9 serdes", serdes_rst, 1); chk("R9 tx", tx_dig_rst, 1);
    chk("R9 rx", rx_dig_rst, 1); chk("R9 state", link_state, 0);

    por_n = 1;
    chk("R1 still held", serdes_rst, 1);
    tick();
    chk("R1 release", serdes_rst, 0);

    // R2 count to the edge before release
    tx_pll_lock = 1;
    tick(TXN - 1);
    chk("R2 early", tx_dig_rst, 1);
    tick();
    chk("R2 release", tx_dig_rst, 0);
    // R3 drop and restart
    tx_pll_lock = 0; tick();
    chk("R3 reassert", tx_dig_rst, 1);
    tx_pll_lock = 1; tick(60);
    tx_pll_lock = 0; tick();
    chk("R3 mid drop", tx_dig_rst, 1);
    tx_pll_lock = 1; tick(TXN - 1);
    chk("R3 restart early", tx_dig_rst, 1);
    tick();
    chk("R3 restart release", tx_dig_rst, 0);

    // R4
    tick(5);
    chk("R4 quiet hold", link_state, 0);
    rx_pll_lock = 1; tick();
    chk("R4 to active", link_state, 1);
    // R6
    phy_status = 1; rx_status = 3'd2; tick();
    chk("R6 code 2", link_state, 1);
    rx_status = 3'd7; tick();
    chk("R6 code 7", link_state, 1);
    phy_status = 0; rx_status = 3'd3; tick();
    chk("R6 no pulse", link_state, 1);
    chk("R7 rx held in active", rx_dig_rst, 1);
    // R5
    phy_status = 1; tick();
    chk("R5 to polling", link_state, 2);
    phy_status = 0; rx_status = 0;
    // R7 window
    sig_det = 1;
    tick(W - 1);
    chk("R7 early", rx_dig_rst, 1);
    tick();
    chk("R7 release", rx_dig_rst, 0);
    // R8
    sig_det = 0; tick();
    chk("R8 reassert", rx_dig_rst, 1);
    sig_det = 1; tick(W - 1);
    chk("R8 restart early", rx_dig_rst, 1);
    tick();
    chk("R8 restart release", rx_dig_rst, 0);

    // random phase: R3 R8 against a run-length model
    void'($urandom(32'd1234));
    tx_run = TXN; rx_run = W;
    for (int c = 0; c < 1500; c++) begin
      tx_pll_lock = ($urandom % 40) != 0;
      sig_det = ($urandom % 30) != 0;
      phy_status = $urandom % 2;
      rx_status = 3'($urandom % 8);
      tick();
      tx_run = tx_pll_lock ? tx_run + 1 : 0;
      rx_run = sig_det ? rx_run + 1 : 0;
      chk("R3 random tx", tx_dig_rst, exp_rst(tx_run, TXN));
      chk("R8 random rx", rx_dig_rst, exp_rst(rx_run, W));
      chk("R5 random state", link_state, 2);
    end

    // R9 mid-run reset
    por_n = 0; tick();
    chk("R9 serdes", serdes_rst, 1); chk("R9 tx", tx_dig_rst, 1);
    chk("R9 rx", rx_dig_rst, 1); chk("R9 state", link_state, 0);
    por_n = 1; tick();
    chk("R1 second release", serdes_rst, 0);
    chk("R4 relock after reset", link_state, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule